// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Wakeup Standby

This block receives 8-bit asynchronous serial characters (one low start bit, eight data bits least significant first, one high stop bit) from a single serial line. Timing comes from a one-cycle tick enable running at sixteen times the bit rate. Each bit is decided by a majority vote of three samples taken near the middle of the bit. A character that passes the start and stop checks is placed on the data output, and a data-full flag rises.

Software can put the receiver into a standby state. In standby it keeps tracking frames but raises no flags, so messages meant for other receivers on a shared line are skipped. Hardware leaves standby on its own when it sees the selected wakeup event. In idle-line mode the event is a quiet line lasting ten bit times. In address-mark mode the event is a character whose top data bit is 1, and that character is delivered. A receiver-enable input turns the whole receiver off.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, rx_full and standby are 0 and rx_data is 0x00.
- R2: A frame made of a start bit at 0, eight data bits sent LSB first and a stop bit at 1, each bit lasting 16 os_tick pulses, sets rx_full and puts the byte on rx_data.
- R3: Each bit takes the majority of its samples at ticks 7, 8 and 9 after the bit starts (the tick that first sees the low start edge is tick 0). A wrong level on only one of those ticks does not change the received byte.
- R4: A low pulse whose start-bit vote is 1 is rejected as a false start. No character is produced.
- R5: A character whose stop-bit vote is 0 is dropped. rx_full and rx_data stay unchanged.
- R6: A one-cycle pulse on rd_strobe clears rx_full in the next cycle.
- R7: While rx_en is 0 the receiver ignores rx_in. No character is produced and the idle count is held at zero.
- R8: A pulse on standby_set sets standby. While standby is 1, characters that do not wake the receiver leave rx_full and rx_data unchanged.
- R9: With wake_addr_mode at 0, standby clears once rx_in has been 1 for 160 consecutive ticks (10 bit times). The count restarts at every low tick. A quiet period that had already run its full length before standby was set does not wake the receiver.
- R10: With wake_addr_mode at 1, a valid character whose bit 7 is 1 clears standby, is put on rx_data and sets rx_full. A character with bit 7 at 0 leaves standby set.
- R11: A new character received while rx_full is still set replaces the unread byte on rx_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Oversample enable, 16 pulses per bit time |
| rx_en | input | 1 | Receiver enable |
| standby_set | input | 1 | Pulse that requests standby |
| wake_addr_mode | input | 1 | Wakeup select: 0 idle line, 1 address mark |
| rd_strobe | input | 1 | Host read of the data register; clears rx_full |
| rx_data | output | 8 | Last delivered character |
| rx_full | output | 1 | Received-data-full flag |
| standby | output | 1 | Standby state |

## Verification
Bytes with alternating, mixed and top-bit-set patterns separate a correct LSB-first shift from a reversed or shifted one. The same byte sent with one-tick glitches moved across ticks 7, 8 and 9 separates a three-sample vote from a single sample at mid-bit. A start pulse only three ticks long, and a stop bit held low through its vote window, show that both frame checks gate delivery. In standby, two quiet gaps of six bit times followed by one gap of more than ten separate a counter that restarts on every low tick from one that keeps adding. In address-mark mode, characters with bit 7 at 0 and at 1 separate wakeup on the mark from wakeup on any character.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              stop_ok;
    } frame_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/uart_wake_sync.sv
module uart_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_wake_sampler.sv
module uart_wake_sampler
    import uart_wake_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  logic   tick,
    input  logic   rxd,
    output logic   done,
    output frame_t frame
);
    localparam int CW   = $clog2(OS_RATE);
    localparam int BW   = $clog2(DATA_W);
    localparam int SMID = OS_RATE / 2;

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [1:0]        votes;
    logic [BW-1:0]     bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              bit_val;

    assign bit_val = vote3({votes[1], votes[0], rxd});

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            votes   <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            done    <= 1'b0;
            frame   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (state == ST_IDLE) begin
                    if (!rxd) begin
                        state <= ST_START;
                        cnt   <= CW'(1);
                    end
                end else begin
                    cnt <= (cnt == CW'(OS_RATE - 1)) ? '0 : cnt + CW'(1);
                    if (cnt == CW'(SMID - 1)) votes[0] <= rxd;
                    if (cnt == CW'(SMID))     votes[1] <= rxd;
                    if (cnt == CW'(SMID + 1)) begin
                        case (state)
                            ST_START: if (bit_val) state <= ST_IDLE;
                            ST_DATA:  shreg <= {bit_val, shreg[DATA_W-1:1]};
                            ST_STOP: begin
                                done          <= 1'b1;
                                frame.data    <= shreg;
                                frame.stop_ok <= bit_val;
                                state         <= ST_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if (cnt == CW'(OS_RATE - 1)) begin
                        case (state)
                            ST_START: begin
                                state   <= ST_DATA;
                                bit_idx <= '0;
                            end
                            ST_DATA: begin
                                if (bit_idx == BW'(DATA_W - 1)) state <= ST_STOP;
                                else bit_idx <= bit_idx + BW'(1);
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_wake_idle.sv
module uart_wake_idle #(
    parameter int OS_RATE   = 16,
    parameter int IDLE_BITS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic tick,
    input  logic rxd,
    output logic idle_hit
);
    localparam int LIMIT = OS_RATE * IDLE_BITS;
    localparam int W     = $clog2(LIMIT + 1);

    logic [W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            run      <= '0;
            idle_hit <= 1'b0;
        end else begin
            idle_hit <= 1'b0;
            if (tick) begin
                if (!rxd) begin
                    run <= '0;
                end else if (run != W'(LIMIT)) begin
                    run <= run + W'(1);
                    if (run == W'(LIMIT - 1)) idle_hit <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
    import uart_wake_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int IDLE_BITS   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_in,
    input  logic              os_tick,
    input  logic              rx_en,
    input  logic              standby_set,
    input  logic              wake_addr_mode,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              standby
);
    logic   rxd;
    logic   done;
    frame_t frame;
    logic   idle_hit;
    logic   addr_wake;
    logic   idle_wake;
    logic   deliver;

    uart_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .dout (rxd)
    );

    uart_wake_sampler #(.OS_RATE(OS_RATE)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .enable (rx_en),
        .tick   (os_tick),
        .rxd    (rxd),
        .done   (done),
        .frame  (frame)
    );

    uart_wake_idle #(.OS_RATE(OS_RATE), .IDLE_BITS(IDLE_BITS)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .enable   (rx_en),
        .tick     (os_tick),
        .rxd      (rxd),
        .idle_hit (idle_hit)
    );

    assign addr_wake = standby && wake_addr_mode && done && frame.stop_ok
                       && frame.data[DATA_W-1];
    assign idle_wake = standby && !wake_addr_mode && idle_hit;
    assign deliver   = done && frame.stop_ok && (!standby || addr_wake);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            rx_full <= 1'b0;
            standby <= 1'b0;
        end else begin
            if (deliver) rx_data <= frame.data;

            if (deliver)        rx_full <= 1'b1;
            else if (rd_strobe) rx_full <= 1'b0;

            if (standby_set)                 standby <= 1'b1;
            else if (addr_wake || idle_wake) standby <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk
    import uart_wake_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic              standby_set,
    input logic              wake_addr_mode,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              standby,
    input logic              frame_done,
    input frame_t            frame,
    input logic              idle_hit
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!rx_full && !standby && rx_data == '0));

    p_full_from_frame_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> $past(frame_done && frame.stop_ok));

    p_bad_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !frame.stop_ok && !rd_strobe) |=> ($stable(rx_full) && $stable(rx_data)));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !frame_done) |=> !rx_full);

    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !frame_done) |=> !$rose(rx_full));

    p_standby_set_r8: assert property (@(posedge clk) disable iff (rst)
        standby_set |=> standby);

    p_standby_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(standby) |-> $past(standby_set));

    p_quiet_idle_mode_r8: assert property (@(posedge clk) disable iff (rst)
        (standby && !wake_addr_mode) |=> !$rose(rx_full));

    p_idle_wake_r9: assert property (@(posedge clk) disable iff (rst)
        (standby && !wake_addr_mode && idle_hit && !standby_set) |=> !standby);

    p_addr_wake_r10: assert property (@(posedge clk) disable iff (rst)
        (standby && wake_addr_mode && frame_done && frame.stop_ok
         && frame.data[DATA_W-1] && !standby_set)
        |=> (!standby && rx_full && rx_data == $past(frame.data)));
endmodule

bind uart_wake_rx uart_wake_rx_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .rx_en          (rx_en),
    .standby_set    (standby_set),
    .wake_addr_mode (wake_addr_mode),
    .rd_strobe      (rd_strobe),
    .rx_data        (rx_data),
    .rx_full        (rx_full),
    .standby        (standby),
    .frame_done     (done),
    .frame          (frame),
    .idle_hit       (idle_hit)
);

// File: tb/test_uart_wake_rx.sv
`timescale 1ns/1ps
module test_uart_wake_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_in = 1'b1;
    logic       os_tick = 1'b0;
    logic       rx_en = 1'b1;
    logic       standby_set = 1'b0;
    logic       wake_addr_mode = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full;
    logic       standby;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    uart_wake_rx i_uart_wake_rx (
        .clk            (clk),
        .rst            (rst),
        .rx_in          (rx_in),
        .os_tick        (os_tick),
        .rx_en          (rx_en),
        .standby_set    (standby_set),
        .wake_addr_mode (wake_addr_mode),
        .rd_strobe      (rd_strobe),
        .rx_data        (rx_data),
        .rx_full        (rx_full),
        .standby        (standby)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One oversample slot: line value held for three clocks, tick on the third.
    task automatic slot(input logic v);
        rx_in   = v;
        os_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        os_tick = 1'b1;
        @(negedge clk);
        os_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) slot(1'b1);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit glitch, input bit bad_stop);
        for (int s = 0; s < 16; s++) slot(1'b0);
        for (int i = 0; i < 8; i++) begin
            for (int s = 0; s < 16; s++) begin
                logic v;
                v = b[i];
                if (glitch && s == 7 + (i % 3)) v = ~v;
                slot(v);
            end
        end
        for (int s = 0; s < 16; s++) slot((bad_stop && s <= 9) ? 1'b0 : 1'b1);
        slot(1'b1);
    endtask

    task automatic host_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic pulse_standby();
        standby_set = 1'b1;
        @(negedge clk);
        standby_set = 1'b0;
    endtask

    task automatic t_reset();
        check(rx_full == 1'b0, "R1 rx_full", int'(rx_full), 0);
        check(standby == 1'b0, "R1 standby", int'(standby), 0);
        check(rx_data == 8'h00, "R1 rx_data", int'(rx_data), 0);
    endtask

    task automatic t_basic();
        send_frame(8'h5A, 0, 0);
        check(rx_full == 1'b1, "R2 full after 0x5A", int'(rx_full), 1);
        check(rx_data == 8'h5A, "R2 data 0x5A", int'(rx_data), 'h5A);
        host_read();
        check(rx_full == 1'b0, "R6 read clears", int'(rx_full), 0);
        send_frame(8'hC3, 0, 0);
        check(rx_data == 8'hC3, "R2 data 0xC3", int'(rx_data), 'hC3);
        host_read();
        send_frame(8'h01, 0, 0);
        check(rx_data == 8'h01, "R2 data 0x01 LSB first", int'(rx_data), 'h01);
        host_read();
    endtask

    task automatic t_glitch();
        send_frame(8'h96, 1, 0);
        check(rx_full == 1'b1, "R3 full after glitched frame", int'(rx_full), 1);
        check(rx_data == 8'h96, "R3 majority vote", int'(rx_data), 'h96);
        host_read();
    endtask

    task automatic t_false_start();
        slot(1'b0); slot(1'b0); slot(1'b0);
        idle(200);
        check(rx_full == 1'b0, "R4 false start", int'(rx_full), 0);
        send_frame(8'h3E, 0, 0);
        check(rx_data == 8'h3E, "R4 receiver recovers", int'(rx_data), 'h3E);
        host_read();
    endtask

    task automatic t_bad_stop();
        send_frame(8'hE7, 0, 1);
        idle(20);
        check(rx_full == 1'b0, "R5 bad stop flag", int'(rx_full), 0);
        check(rx_data == 8'h3E, "R5 bad stop data", int'(rx_data), 'h3E);
    endtask

    task automatic t_overwrite();
        send_frame(8'h11, 0, 0);
        send_frame(8'h22, 0, 0);
        check(rx_full == 1'b1, "R11 full kept", int'(rx_full), 1);
        check(rx_data == 8'h22, "R11 newest byte", int'(rx_data), 'h22);
        host_read();
    endtask

    task automatic t_disabled();
        rx_en = 1'b0;
        send_frame(8'h77, 0, 0);
        rx_en = 1'b1;
        idle(20);
        check(rx_full == 1'b0, "R7 disabled flag", int'(rx_full), 0);
        check(rx_data == 8'h22, "R7 disabled data", int'(rx_data), 'h22);
    endtask

    task automatic t_idle_wake();
        wake_addr_mode = 1'b0;
        idle(200);
        pulse_standby();
        check(standby == 1'b1, "R8 standby set", int'(standby), 1);
        idle(200);
        check(standby == 1'b1, "R9 old idle no wake", int'(standby), 1);
        send_frame(8'h3C, 0, 0);
        check(rx_full == 1'b0, "R8 no flag in standby", int'(rx_full), 0);
        idle(80);
        send_frame(8'h66, 0, 0);
        idle(80);
        check(standby == 1'b1, "R9 short gaps keep standby", int'(standby), 1);
        check(rx_full == 1'b0, "R8 no flag in standby 2", int'(rx_full), 0);
        idle(80);
        check(standby == 1'b0, "R9 idle wake", int'(standby), 0);
        send_frame(8'h81, 0, 0);
        check(rx_full == 1'b1, "R9 after wake flag", int'(rx_full), 1);
        check(rx_data == 8'h81, "R9 after wake data", int'(rx_data), 'h81);
        host_read();
    endtask

    task automatic t_addr_wake();
        wake_addr_mode = 1'b1;
        pulse_standby();
        send_frame(8'h35, 0, 0);
        check(standby == 1'b1, "R10 no mark keeps standby", int'(standby), 1);
        check(rx_full == 1'b0, "R8 no flag for 0x35", int'(rx_full), 0);
        send_frame(8'hA7, 0, 0);
        check(standby == 1'b0, "R10 mark wakes", int'(standby), 0);
        check(rx_full == 1'b1, "R10 mark flag", int'(rx_full), 1);
        check(rx_data == 8'hA7, "R10 mark data", int'(rx_data), 'hA7);
        host_read();
        send_frame(8'h12, 0, 0);
        check(rx_data == 8'h12, "R10 normal after wake", int'(rx_data), 'h12);
        host_read();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        idle(20);
        t_basic();
        t_glitch();
        t_false_start();
        t_bad_stop();
        t_overwrite();
        t_disabled();
        t_idle_wake();
        t_addr_wake();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule